// File: doc/BRIEF.md
# Large Warp Sub-Warp Former

This block takes a large warp of R rows of SIMT-width threads, together with the activity mask left after a divergent branch. It breaks the large warp into issue-sized sub-warps. Each cycle that the issue stage is ready, it forms one sub-warp. Every lane of that sub-warp receives at most one thread, and that thread must come from the lane's own column of the large warp. The threads it issues are then removed from the remaining mask. When no thread is left, the block pulses a completion flag and returns to idle, ready for the next large warp.

Threads stay on their home lane: thread t may only use lane t mod LANES. Each lane therefore keeps reading only its own register file bank, with no operand crossbar. Because active threads from different rows are packed into one slot, the number of issue slots equals the busiest lane's thread count rather than the number of non-empty rows.

Top module: `lw_subwarp_former`

## Requirements
- R1: After reset, sw_valid_o and done_o are low and issued_cnt_o is 0.
- R2: A load_i pulse is taken only while the block is idle. A load_i pulse while a large warp is being formed or done is being signalled is ignored, and the remaining mask is unchanged.
- R3: sw_valid_o is high in a cycle only if ready_i is high and at least one thread remains. At most one sub-warp is formed per cycle.
- R4: For each lane, the sub-warp picks the lowest-numbered row whose bit is still set in that lane's column. The remaining-mask bit index is row*LANES+lane. The lane's bit in sw_lane_act_o is set exactly when its column has a remaining bit. Its field in sw_tid_o, which is TID_W bits wide at offset lane*TID_W, holds row*LANES+lane.
- R5: Threads issued in a sub-warp are cleared from the remaining mask. issued_cnt_o rises by one per sub-warp and is cleared when a new large warp is accepted.
- R6: done_o is high for exactly one cycle, in the cycle after the edge that issued the last sub-warp, and the block is idle in the cycle after that.
- R7: At done, issued_cnt_o equals the largest per-lane count of active threads in the loaded mask. An all-zero mask gives done with a count of 0, one cycle after the load is accepted.
- R8: Whenever sw_valid_o is high, at least one bit of sw_lane_act_o is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load strobe for a new large warp |
| mask_i | input | LANES*ROWS | Activity mask, bit row*LANES+lane |
| ready_i | input | 1 | Issue stage can take a sub-warp |
| sw_valid_o | output | 1 | Sub-warp issued this cycle |
| sw_tid_o | output | LANES*TID_W | Per-lane thread index |
| sw_lane_act_o | output | LANES | Per-lane active bits |
| done_o | output | 1 | One-cycle completion pulse |
| issued_cnt_o | output | CNT_W | Sub-warps issued for the current large warp |

## Verification
A corrupted remaining mask shows up in the same cycle as a wrong lane-active bit or a wrong thread index on the next sub-warp. It shows up later as a sub-warp count that departs from the busiest lane's population at done. A stuck or mis-stepped controller shows up as valid without ready, as a missing or doubled done pulse, or as a second load that disturbs the running warp. The bench models the mask as a plain bit array and checks every output on every cycle, so any divergence is reported in the cycle it first appears.

// File: rtl/lw_pkg.sv
package lw_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} lw_state_e;
endpackage

// File: rtl/lw_lane_pick.sv
module lw_lane_pick #(
  parameter int ROWS  = 4,
  parameter int ROW_W = 2
) (
  input  logic [ROWS-1:0]  col_i,
  output logic             act_o,
  output logic [ROW_W-1:0] row_o,
  output logic [ROWS-1:0]  clr_o
);
  // lowest set row wins
  always_comb begin
    row_o = '0;
    clr_o = '0;
    for (int r = ROWS-1; r >= 0; r--) begin
      if (col_i[r]) begin
        row_o = ROW_W'(r);
        clr_o = ROWS'(1) << r;
      end
    end
  end
  assign act_o = |col_i;
endmodule

// File: rtl/lw_issue_ctrl.sv
module lw_issue_ctrl
  import lw_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             ready_i,
  input  logic             pend_i,
  input  logic             left_i,
  output logic             load_en_o,
  output logic             fire_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  lw_state_e state_q, state_d;

  assign load_en_o = (state_q == ST_IDLE) && load_i;
  assign fire_o    = (state_q == ST_RUN) && pend_i && ready_i;
  assign done_o    = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load_i) state_d = ST_RUN;
      ST_RUN:  if (!pend_i || (fire_o && !left_i)) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_o   <= '0;
    end else begin
      state_q <= state_d;
      if (load_en_o)   cnt_o <= '0;
      else if (fire_o) cnt_o <= cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/lw_subwarp_former.sv
module lw_subwarp_former #(
  parameter int LANES = 32,
  parameter int ROWS  = 4,
  localparam int NB    = LANES * ROWS,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int TID_W = (NB > 1) ? $clog2(NB) : 1,
  localparam int CNT_W = $clog2(ROWS + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [NB-1:0]          mask_i,
  input  logic                   ready_i,
  output logic                   sw_valid_o,
  output logic [LANES*TID_W-1:0] sw_tid_o,
  output logic [LANES-1:0]       sw_lane_act_o,
  output logic                   done_o,
  output logic [CNT_W-1:0]       issued_cnt_o
);
  logic [NB-1:0]    rem_q;
  logic [NB-1:0]    clr_all;
  logic [LANES-1:0] act;
  logic             load_en, fire;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ROWS-1:0]  col, clr;
    logic [ROW_W-1:0] row;
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign col[r]              = rem_q[r*LANES+l];
      assign clr_all[r*LANES+l]  = clr[r];
    end
    lw_lane_pick #(.ROWS(ROWS), .ROW_W(ROW_W)) u_pick (
      .col_i(col), .act_o(act[l]), .row_o(row), .clr_o(clr)
    );
    assign sw_tid_o[l*TID_W +: TID_W] =
      TID_W'(TID_W'(row) * TID_W'(LANES) + TID_W'(l));
  end

  logic [NB-1:0] rem_next;
  assign rem_next = rem_q & ~clr_all;

  lw_issue_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .ready_i(ready_i),
    .pend_i(|rem_q), .left_i(|rem_next),
    .load_en_o(load_en), .fire_o(fire), .done_o(done_o), .cnt_o(issued_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rem_q <= '0;
    else if (load_en) rem_q <= mask_i;
    else if (fire)    rem_q <= rem_next;
  end

  assign sw_valid_o    = fire;
  assign sw_lane_act_o = act & {LANES{fire}};
endmodule

// File: rtl/lw_subwarp_former_chk.sv
module lw_subwarp_former_chk #(
  parameter int LANES = 32,
  parameter int ROWS  = 4,
  localparam int CNT_W = $clog2(ROWS + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ready_i,
  input logic             sw_valid_o,
  input logic [LANES-1:0] sw_lane_act_o,
  input logic             done_o,
  input logic [CNT_W-1:0] issued_cnt_o
);
  // R3
  valid_needs_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_valid_o |-> ready_i);
  // R8
  valid_has_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_valid_o |-> (sw_lane_act_o != '0));
  // R5
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_valid_o |=> (issued_cnt_o == $past(issued_cnt_o) + CNT_W'(1)));
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  done_no_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !sw_valid_o);
  // R7
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issued_cnt_o <= CNT_W'(ROWS));
endmodule

bind lw_subwarp_former lw_subwarp_former_chk #(.LANES(LANES), .ROWS(ROWS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ready_i(ready_i), .sw_valid_o(sw_valid_o),
  .sw_lane_act_o(sw_lane_act_o), .done_o(done_o), .issued_cnt_o(issued_cnt_o)
);

// File: tb/tb_lw_subwarp_former.sv
module tb_lw_subwarp_former;
  localparam int LANES = 32;
  localparam int ROWS  = 4;
  localparam int NB    = LANES * ROWS;
  localparam int TID_W = $clog2(NB);
  localparam int CNT_W = $clog2(ROWS + 1);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic load_i = 1'b0;
  logic [NB-1:0] mask_i = '0;
  logic ready_i = 1'b0;
  logic sw_valid_o, done_o;
  logic [LANES*TID_W-1:0] sw_tid_o;
  logic [LANES-1:0] sw_lane_act_o;
  logic [CNT_W-1:0] issued_cnt_o;

  always #4 clk_i = ~clk_i;

  lw_subwarp_former #(.LANES(LANES), .ROWS(ROWS)) dut (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  // model: 0 idle, 1 forming, 2 done
  int ms = 0, mcnt = 0, mmax = 0;
  logic [NB-1:0] mrem = '0;

  task automatic check(input string tag, input longint got, input longint exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input bit ld, input logic [NB-1:0] m, input bit rdy);
    bit exp_v;
    logic [LANES-1:0] eact;
    @(negedge clk_i);
    load_i = ld; mask_i = m; ready_i = rdy;
    #1;
    exp_v = (ms == 1) && (mrem != '0) && rdy;
    check("R3 valid", sw_valid_o, exp_v);
    check("R6 done", done_o, ms == 2);
    check("R5 count", issued_cnt_o, mcnt);
    if (ms == 2) check("R7 final count", issued_cnt_o, mmax);
    if (ld && ms != 0) check("R2 load ignored", sw_valid_o, exp_v);
    eact = '0;
    if (exp_v) begin
      for (int l = 0; l < LANES; l++) begin
        for (int r = 0; r < ROWS; r++) begin
          if (mrem[r*LANES+l] && !eact[l]) begin
            eact[l] = 1'b1;
            check("R4 tid", sw_tid_o[l*TID_W +: TID_W], r*LANES + l);
            mrem[r*LANES+l] = 1'b0;
          end
        end
      end
      check("R4 lanes", sw_lane_act_o, eact);
      check("R8 nonempty", sw_lane_act_o != '0, 1);
    end
    // advance model to next edge
    if (ms == 0) begin
      if (ld) begin
        mrem = m; mcnt = 0; ms = 1; mmax = 0;
        for (int l = 0; l < LANES; l++) begin
          int c = 0;
          for (int r = 0; r < ROWS; r++) c += int'(m[r*LANES+l]);
          if (c > mmax) mmax = c;
        end
      end
    end else if (ms == 1) begin
      if (exp_v) mcnt++;
      if (mrem == '0) ms = 2;
    end else ms = 0;
  endtask

  task automatic run_warp(input logic [NB-1:0] m, input int stall, input bit poke);
    step(1'b1, m, 1'b1);
    for (int k = 0; k < 40 && ms != 0; k++)
      step(poke && k < 2, ~m, (stall == 0) || (k % stall != 0));
    step(1'b0, '0, 1'b1);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [NB-1:0] m;
    repeat (2) @(negedge clk_i);
    #1;
    check("R1 valid", sw_valid_o, 0);
    check("R1 done", done_o, 0);
    check("R1 count", issued_cnt_o, 0);
    rst_ni = 1'b1;
    run_warp({NB{1'b1}}, 0, 1'b0);                 // full: 4 slots
    m = '0; m[2*LANES +: LANES] = '1;
    run_warp(m, 0, 1'b0);                          // one row
    m = '0;
    for (int l = 0; l < LANES; l++) m[(l % ROWS)*LANES + l] = 1'b1;
    run_warp(m, 0, 1'b0);                          // diagonal: one slot
    run_warp('0, 0, 1'b0);                         // empty mask, R7
    m = '0; for (int r = 0; r < ROWS; r++) m[r*LANES + 5] = 1'b1; m[1] = 1'b1;
    run_warp(m, 3, 1'b0);                          // stalls on ready
    run_warp({NB{1'b1}} ^ NB'(12345), 0, 1'b1);    // R2 load poke
    for (int t = 0; t < 30; t++) begin
      for (int w = 0; w < NB/32; w++) m[w*32 +: 32] = $urandom & $urandom;
      run_warp(m, t % 4, t[0]);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule